// File: doc/BRIEF.md
# Raster Timing Generator with Frame-Synchronous Configuration Commit

This block produces the raster timing for a parallel RGB panel. From an active size, a front porch, a sync pulse width and a back porch for each direction, it runs a pixel counter and a line counter. It drives horizontal sync, vertical sync, data-enable, the current column and line, and a vertical-blank status with an interrupt output. Each line is laid out as active pixels, front porch, sync pulse and back porch, in that order. Each frame uses the same order, counted in lines.

Software places new timing on the staged inputs and raises a one-cycle commit request. The staged values are copied into the working set only at a frame boundary, so a frame never mixes two configurations. Clearing the enable input lets the current frame run to its last pixel before the raster stops. A synchronous soft reset returns the timing state to idle without losing the working configuration. A polarity bit for each sync and data-enable output, and a flag that selects the pixel-clock edge for driving data, travel with the committed configuration.

Top module: `disp_timing_gen`

## Requirements
- R1: After `rst`, the raster is idle: `disp_on`, `commit_pend` and `vblank_stat` are 0; `hsync_o`, `vsync_o` and `de_o` are 0; `pix_x` and `pix_y` are 0.
- R2: While running, every line is ACT+FP+SYNC+BP pixel clocks long in horizontal units. The raw horizontal sync is asserted exactly for columns ACT+FP up to ACT+FP+SYNC-1.
- R3: Every frame is ACT+FP+SYNC+BP lines in vertical units. The raw vertical sync is asserted for whole lines ACT+FP up to ACT+FP+SYNC-1.
- R4: `de_o` is raw-active only when the column is below the horizontal ACT and the line is below the vertical ACT. Every output is registered, so the outputs for raster position k appear one clock after the counters hold k. `pix_x` and `pix_y` give that column and line.
- R5: A committed polarity bit of 1 inverts the corresponding output, and that includes its idle level.
- R6: `neg_edge_o` follows the committed pixel-edge select bit, one clock after the commit.
- R7: `commit_req` sets `commit_pend`. The staged inputs enter the working set at the last pixel of the frame, and `commit_pend` reads 0 from that same clock edge on.
- R8: While idle, every clock counts as a frame boundary, so a pending commit completes on the clock after the request.
- R9: With `disp_en` high, an idle raster starts at column 0, line 0. After `disp_en` falls, `disp_on` stays 1 until the last pixel of the current frame has been produced, then the outputs go idle.
- R10: `vblank_stat` becomes 1 at column 0 of line ACT (vertical). A `vblank_clr` pulse clears it, and a coinciding set wins.
- R11: `vblank_irq` is 1 exactly when `vblank_stat` and `vblank_ie` are both 1.
- R12: `sw_reset` stops the raster, drops any pending commit and clears `vblank_stat`. The working configuration is kept, and the outputs are idle two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_reset | input | 1 | Soft reset of timing state |
| disp_en | input | 1 | Display enable request |
| stg_h_act | input | 12 | Staged active pixels per line |
| stg_h_fp | input | 12 | Staged horizontal front porch |
| stg_h_sync | input | 12 | Staged horizontal sync width |
| stg_h_bp | input | 12 | Staged horizontal back porch |
| stg_v_act | input | 12 | Staged active lines per frame |
| stg_v_fp | input | 12 | Staged vertical front porch |
| stg_v_sync | input | 12 | Staged vertical sync width |
| stg_v_bp | input | 12 | Staged vertical back porch |
| stg_inv_hs | input | 1 | Staged horizontal sync inversion |
| stg_inv_vs | input | 1 | Staged vertical sync inversion |
| stg_inv_de | input | 1 | Staged data-enable inversion |
| stg_neg_edge | input | 1 | Staged pixel-edge select |
| commit_req | input | 1 | One-cycle commit request |
| commit_pend | output | 1 | Commit waiting for a frame boundary |
| disp_on | output | 1 | Raster running status |
| vblank_clr | input | 1 | Clear vertical-blank status |
| vblank_ie | input | 1 | Vertical-blank interrupt enable |
| vblank_stat | output | 1 | Vertical-blank status |
| vblank_irq | output | 1 | Vertical-blank interrupt |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_x | output | 12 | Current column |
| pix_y | output | 12 | Current line |
| neg_edge_o | output | 1 | Committed pixel-edge select |

## Verification
The bench uses the default 12-bit counters with two tiny rasters: 10 pixels by 7 lines, and an inverted 7 by 6 raster committed mid-frame. Frames of 70 and 42 clocks let the bench compare every output at every raster position across several whole frames. That covers the switch between configurations, an enable drop in the middle of a frame, and the status clear just after its set point. All of this fits in a few hundred clocks.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned DTG_CW = 12;

  typedef logic [DTG_CW-1:0] dtg_cnt_t;

  typedef struct packed {
    dtg_cnt_t act;
    dtg_cnt_t fp;
    dtg_cnt_t sync;
    dtg_cnt_t bp;
  } dtg_axis_cfg_t;

  typedef struct packed {
    dtg_axis_cfg_t h;
    dtg_axis_cfg_t v;
    logic          inv_hs;
    logic          inv_vs;
    logic          inv_de;
    logic          neg_edge;
  } dtg_cfg_t;

  localparam dtg_axis_cfg_t DTG_AXIS_RST = '{
    act: DTG_CW'(1), fp: DTG_CW'(1), sync: DTG_CW'(1), bp: DTG_CW'(1)
  };

  localparam dtg_cfg_t DTG_CFG_RST = '{
    h: DTG_AXIS_RST, v: DTG_AXIS_RST,
    inv_hs: 1'b0, inv_vs: 1'b0, inv_de: 1'b0, neg_edge: 1'b0
  };
endpackage

// File: rtl/dtg_axis.sv
module dtg_axis
  import dtg_pkg::*;
#(
  parameter int unsigned CW = DTG_CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  dtg_axis_cfg_t cfg,
  output logic [CW-1:0] cnt,
  output logic          last,
  output logic          in_act,
  output logic          in_sync
);
  localparam int unsigned SW = CW + 2;

  logic [SW-1:0] tot;
  logic [SW-1:0] sync_beg;
  logic [SW-1:0] sync_end;
  logic [SW-1:0] cnt_w;

  always_comb begin
    tot      = SW'(cfg.act) + SW'(cfg.fp) + SW'(cfg.sync) + SW'(cfg.bp);
    sync_beg = SW'(cfg.act) + SW'(cfg.fp);
    sync_end = sync_beg + SW'(cfg.sync);
    cnt_w    = SW'(cnt);
    last     = (cnt_w == tot - SW'(1));
    in_act   = (cnt_w < SW'(cfg.act));
    in_sync  = (cnt_w >= sync_beg) && (cnt_w < sync_end);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= last ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/dtg_shadow.sv
module dtg_shadow
  import dtg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sw_reset,
  input  logic     req,
  input  logic     boundary,
  input  dtg_cfg_t staged,
  output dtg_cfg_t active,
  output logic     pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= DTG_CFG_RST;
      pend   <= 1'b0;
    end else if (sw_reset) begin
      pend   <= 1'b0;
    end else if (pend && boundary) begin
      active <= staged;
      pend   <= req;
    end else if (req) begin
      pend   <= 1'b1;
    end
  end
endmodule

// File: rtl/dtg_ctrl.sv
module dtg_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic sw_reset,
  input  logic disp_en,
  input  logic frame_end,
  input  logic vb_pulse,
  input  logic vb_clr,
  output logic run,
  output logic vb_stat
);
  always_ff @(posedge clk) begin
    if (rst || sw_reset) begin
      run <= 1'b0;
    end else if (!run) begin
      run <= disp_en;
    end else if (frame_end && !disp_en) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sw_reset) begin
      vb_stat <= 1'b0;
    end else if (vb_pulse) begin
      vb_stat <= 1'b1;
    end else if (vb_clr) begin
      vb_stat <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_reset,
  input  logic              disp_en,
  input  logic [DTG_CW-1:0] stg_h_act,
  input  logic [DTG_CW-1:0] stg_h_fp,
  input  logic [DTG_CW-1:0] stg_h_sync,
  input  logic [DTG_CW-1:0] stg_h_bp,
  input  logic [DTG_CW-1:0] stg_v_act,
  input  logic [DTG_CW-1:0] stg_v_fp,
  input  logic [DTG_CW-1:0] stg_v_sync,
  input  logic [DTG_CW-1:0] stg_v_bp,
  input  logic              stg_inv_hs,
  input  logic              stg_inv_vs,
  input  logic              stg_inv_de,
  input  logic              stg_neg_edge,
  input  logic              commit_req,
  output logic              commit_pend,
  output logic              disp_on,
  input  logic              vblank_clr,
  input  logic              vblank_ie,
  output logic              vblank_stat,
  output logic              vblank_irq,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [DTG_CW-1:0] pix_x,
  output logic [DTG_CW-1:0] pix_y,
  output logic              neg_edge_o
);
  dtg_cfg_t          staged;
  dtg_cfg_t          act_cfg;
  logic              pend;
  logic              run;
  logic              vb_stat;
  logic [DTG_CW-1:0] hcnt;
  logic [DTG_CW-1:0] vcnt;
  logic              h_last, v_last;
  logic              h_act, v_act;
  logic              h_sync, v_sync;
  logic              h_wrap;
  logic              frame_end;
  logic              boundary;
  logic              vb_pulse;

  always_comb begin
    staged.h        = '{act: stg_h_act, fp: stg_h_fp, sync: stg_h_sync, bp: stg_h_bp};
    staged.v        = '{act: stg_v_act, fp: stg_v_fp, sync: stg_v_sync, bp: stg_v_bp};
    staged.inv_hs   = stg_inv_hs;
    staged.inv_vs   = stg_inv_vs;
    staged.inv_de   = stg_inv_de;
    staged.neg_edge = stg_neg_edge;
  end

  assign h_wrap    = run && h_last;
  assign frame_end = h_wrap && v_last;
  assign boundary  = !run || frame_end;
  assign vb_pulse  = run && (hcnt == '0) && (vcnt == act_cfg.v.act);

  dtg_shadow u_shadow (
    .clk      (clk),
    .rst      (rst),
    .sw_reset (sw_reset),
    .req      (commit_req),
    .boundary (boundary),
    .staged   (staged),
    .active   (act_cfg),
    .pend     (pend)
  );

  dtg_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sw_reset  (sw_reset),
    .disp_en   (disp_en),
    .frame_end (frame_end),
    .vb_pulse  (vb_pulse),
    .vb_clr    (vblank_clr),
    .run       (run),
    .vb_stat   (vb_stat)
  );

  dtg_axis #(.CW(DTG_CW)) u_hax (
    .clk     (clk),
    .rst     (rst),
    .clr     (sw_reset || !run),
    .step    (run),
    .cfg     (act_cfg.h),
    .cnt     (hcnt),
    .last    (h_last),
    .in_act  (h_act),
    .in_sync (h_sync)
  );

  dtg_axis #(.CW(DTG_CW)) u_vax (
    .clk     (clk),
    .rst     (rst),
    .clr     (sw_reset || !run),
    .step    (h_wrap),
    .cfg     (act_cfg.v),
    .cnt     (vcnt),
    .last    (v_last),
    .in_act  (v_act),
    .in_sync (v_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      de_o       <= 1'b0;
      pix_x      <= '0;
      pix_y      <= '0;
      neg_edge_o <= 1'b0;
    end else begin
      hsync_o    <= (run && h_sync) ^ act_cfg.inv_hs;
      vsync_o    <= (run && v_sync) ^ act_cfg.inv_vs;
      de_o       <= (run && h_act && v_act) ^ act_cfg.inv_de;
      pix_x      <= run ? hcnt : '0;
      pix_y      <= run ? vcnt : '0;
      neg_edge_o <= act_cfg.neg_edge;
    end
  end

  assign commit_pend = pend;
  assign disp_on     = run;
  assign vblank_stat = vb_stat;
  assign vblank_irq  = vb_stat && vblank_ie;
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk (
  input logic clk,
  input logic rst,
  input logic sw_reset,
  input logic run,
  input logic frame_end,
  input logic boundary,
  input logic pend,
  input logic vb_pulse,
  input logic vb_stat,
  input logic de_o,
  input logic inv_de
);
  // R7
  pend_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> $past(boundary || sw_reset));

  // R9
  run_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> $past(frame_end || sw_reset));

  // R10
  vb_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vb_stat) |-> $past(vb_pulse));

  // R4
  de_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (de_o != $past(inv_de)) |-> $past(run));

  // R12
  soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sw_reset) |-> (!run && !pend && !vb_stat));
endmodule

bind disp_timing_gen dtg_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sw_reset  (sw_reset),
  .run       (run),
  .frame_end (frame_end),
  .boundary  (boundary),
  .pend      (pend),
  .vb_pulse  (vb_pulse),
  .vb_stat   (vb_stat),
  .de_o      (de_o),
  .inv_de    (act_cfg.inv_de)
);

// File: tb/disp_timing_gen_tb.sv
`timescale 1ns/1ps
module disp_timing_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_reset = 1'b0;
  logic disp_en = 1'b0;
  logic [11:0] stg_h_act = '0, stg_h_fp = '0, stg_h_sync = '0, stg_h_bp = '0;
  logic [11:0] stg_v_act = '0, stg_v_fp = '0, stg_v_sync = '0, stg_v_bp = '0;
  logic stg_inv_hs = 1'b0, stg_inv_vs = 1'b0, stg_inv_de = 1'b0, stg_neg_edge = 1'b0;
  logic commit_req = 1'b0;
  logic vblank_clr = 1'b0;
  logic vblank_ie = 1'b0;
  logic commit_pend, disp_on, vblank_stat, vblank_irq;
  logic hsync_o, vsync_o, de_o, neg_edge_o;
  logic [11:0] pix_x, pix_y;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  disp_timing_gen u_dut (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .disp_en(disp_en),
    .stg_h_act(stg_h_act), .stg_h_fp(stg_h_fp), .stg_h_sync(stg_h_sync), .stg_h_bp(stg_h_bp),
    .stg_v_act(stg_v_act), .stg_v_fp(stg_v_fp), .stg_v_sync(stg_v_sync), .stg_v_bp(stg_v_bp),
    .stg_inv_hs(stg_inv_hs), .stg_inv_vs(stg_inv_vs), .stg_inv_de(stg_inv_de),
    .stg_neg_edge(stg_neg_edge), .commit_req(commit_req), .commit_pend(commit_pend),
    .disp_on(disp_on), .vblank_clr(vblank_clr), .vblank_ie(vblank_ie),
    .vblank_stat(vblank_stat), .vblank_irq(vblank_irq), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .pix_x(pix_x), .pix_y(pix_y), .neg_edge_o(neg_edge_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Raster geometry for one configuration, indexed by position in the frame.
  task automatic check_px(input string rq_h, input string rq_v, input string rq_d, input int idx,
                          input int ha, input int hf, input int hs, input int hb,
                          input int va, input int vf, input int vs, input int vb,
                          input bit ihs, input bit ivs, input bit ide);
    int htot, x, y;
    bit ehs, evs, ede;
    htot = ha + hf + hs + hb;
    x = idx % htot;
    y = idx / htot;
    ehs = (x >= ha + hf) && (x < ha + hf + hs);
    evs = (y >= va + vf) && (y < va + vf + vs);
    ede = (x < ha) && (y < va);
    check(rq_h, "hsync", int'(hsync_o), int'(ehs ^ ihs));
    check(rq_v, "vsync", int'(vsync_o), int'(evs ^ ivs));
    check(rq_d, "de", int'(de_o), int'(ede ^ ide));
    check("R4", "pix_x", int'(pix_x), x);
    check("R4", "pix_y", int'(pix_y), y);
  endtask

  task automatic stage(input int ha, input int hf, input int hs, input int hb,
                       input int va, input int vf, input int vs, input int vb,
                       input bit ihs, input bit ivs, input bit ide, input bit ne);
    stg_h_act = 12'(ha); stg_h_fp = 12'(hf); stg_h_sync = 12'(hs); stg_h_bp = 12'(hb);
    stg_v_act = 12'(va); stg_v_fp = 12'(vf); stg_v_sync = 12'(vs); stg_v_bp = 12'(vb);
    stg_inv_hs = ihs; stg_inv_vs = ivs; stg_inv_de = ide; stg_neg_edge = ne;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 idle state after reset
    check("R1", "disp_on", int'(disp_on), 0);
    check("R1", "commit_pend", int'(commit_pend), 0);
    check("R1", "vblank_stat", int'(vblank_stat), 0);
    check("R1", "hsync", int'(hsync_o), 0);
    check("R1", "vsync", int'(vsync_o), 0);
    check("R1", "de", int'(de_o), 0);
    check("R1", "pix_x", int'(pix_x), 0);
    check("R1", "pix_y", int'(pix_y), 0);

    // Configuration A: 10 x 7 raster, no inversion
    stage(4, 2, 3, 1, 3, 1, 2, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    commit_req = 1'b1;
    vblank_ie = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
    check("R7", "pend after request", int'(commit_pend), 1);
    @(negedge clk);
    check("R8", "pend after idle commit", int'(commit_pend), 0);
    disp_en = 1'b1;
    @(posedge clk);

    for (int k = 0; k < 200; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k < 70) begin
        check_px("R2", "R3", "R4", k, 4, 2, 3, 1, 3, 1, 2, 1, 1'b0, 1'b0, 1'b0);
        check("R6", "neg_edge", int'(neg_edge_o), 0);
      end else if (k < 196) begin
        check_px("R5", "R3", "R5", (k - 70) % 42, 3, 1, 1, 2, 2, 2, 1, 1, 1'b1, 1'b0, 1'b1);
        check("R6", "neg_edge", int'(neg_edge_o), 1);
      end else begin
        check("R5", "idle hsync", int'(hsync_o), 1);
        check("R5", "idle de", int'(de_o), 1);
        check("R9", "idle vsync", int'(vsync_o), 0);
        check("R9", "idle pix_x", int'(pix_x), 0);
        check("R9", "idle pix_y", int'(pix_y), 0);
      end
      check("R9", "disp_on", int'(disp_on), (k < 195) ? 1 : 0);
      check("R7", "commit_pend", int'(commit_pend), (k >= 11 && k <= 68) ? 1 : 0);
      if (k == 70) check("R10", "vblank_stat", int'(vblank_stat), 1);
      else if (k >= 71 && k <= 83) check("R10", "vblank_stat", int'(vblank_stat), 0);
      else check("R10", "vblank_stat", int'(vblank_stat), (k >= 30) ? 1 : 0);
      check("R11", "vblank_irq", int'(vblank_irq), int'(vblank_stat));
      // stimulus after sampling
      commit_req = 1'b0;
      vblank_clr = 1'b0;
      if (k == 10) begin
        // Configuration B: 7 x 6 raster, inverted hsync and de, falling edge
        stage(3, 1, 1, 2, 2, 2, 1, 1, 1'b1, 1'b0, 1'b1, 1'b1);
        commit_req = 1'b1;
      end
      if (k == 70) vblank_clr = 1'b1;
      if (k == 160) disp_en = 1'b0;
    end

    vblank_ie = 1'b0;
    @(negedge clk);
    check("R11", "irq masked", int'(vblank_irq), 0);
    check("R10", "stat held", int'(vblank_stat), 1);

    disp_en = 1'b1;
    repeat (5) @(negedge clk);
    check("R9", "restart", int'(disp_on), 1);
    commit_req = 1'b1;
    disp_en = 1'b0;
    sw_reset = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
    sw_reset = 1'b0;
    @(negedge clk);
    check("R12", "disp_on", int'(disp_on), 0);
    check("R12", "commit_pend", int'(commit_pend), 0);
    check("R12", "vblank_stat", int'(vblank_stat), 0);
    check("R12", "hsync idle", int'(hsync_o), 1);
    check("R12", "de idle", int'(de_o), 1);
    check("R12", "vsync idle", int'(vsync_o), 0);
    check("R12", "pix_x", int'(pix_x), 0);
    check("R12", "neg_edge kept", int'(neg_edge_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule